// File: doc/BRIEF.md
# Register File with Abort Rollback

This block holds the working registers of a small processor core: five general registers (A, X, Y, B, E), a user stack pointer and a supervisor stack pointer, each picked by a 3-bit register number, plus an 8-bit status register. Reads are synchronous. The register number is captured on a clock edge, and the selected value appears on the read output after that edge. The output then holds that value until the next valid read. One write port works in the same cycle as the read, so the storage suits a block RAM with a registered read.

The two stack pointers and the status register each keep a fallback copy next to their working copy. The instruction sequencer pulses an instruction-end strobe to commit the working values into the fallbacks. It pulses an abort strobe when an access faults, and the committed values are then copied back. A faulting instruction therefore leaves the stack pointers and flags as they were before it started. The general registers have no fallback copy.

Top module: `rbk_regfile`

## Requirements
- R1: Register numbers select A=0, X=1, Y=2, B=3, E=4, user stack pointer=5 and supervisor stack pointer=6. A value written to a number is later read back from that same number. Number 7 selects nothing.
- R2: When rdEn is high and rdSel is 0..6 at a rising edge, rdData shows that register's content from after that edge onward.
- R3: When rdEn is low, or rdSel is 7, at an edge, rdData keeps its previous value.
- R4: A read and a write to the same register in one cycle return the old content. The new content is returned by a later read.
- R5: A write with wrSel=7 changes no register.
- R6: When instrDone is high and abortReq is low, the fallback copies of both stack pointers and the status register take the values the working copies hold after that edge, including any write made in the same cycle.
- R7: When abortReq is high, both stack pointers and the status register are reloaded from their fallbacks. A register or flag write to those three in the same cycle is dropped, while a write to A..E in that cycle still takes effect.
- R8: When abortReq and instrDone are both high, the abort wins and the fallback copies keep their previous values.
- R9: statusOut bits are [7]=N, [6]=V, [5]=u (1 = user mode), [4]=x (extended stack frame), [3]=D, [2]=I, [1]=Z, [0]=C. After reset it reads 8'h04, and all registers, fallbacks and rdData read 0. With flagWe high and abortReq low, flagData appears on statusOut after the edge, and otherwise statusOut holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read request |
| rdSel | input | 3 | Read register number |
| wrEn | input | 1 | Write request |
| wrSel | input | 3 | Write register number |
| wrData | input | DATA_W | Write value |
| flagWe | input | 1 | Status register load |
| flagData | input | 8 | Status value to load |
| instrDone | input | 1 | Instruction end: commit the fallback copies |
| abortReq | input | 1 | Abort: restore from the fallback copies |
| rdData | output | DATA_W | Registered read value |
| statusOut | output | 8 | Working status register |

## Verification
Every result in this block is due exactly one edge after the stimulus that causes it. rdData and statusOut both change on the same rising edge that samples rdSel, the write port or the strobes. A commit or a rollback becomes visible only through a later read or a later abort, one edge after that request. The driver applies each stimulus on a falling edge, waits for the following rising edge, and only then queues the value it predicts. The monitor compares on the next falling edge, so each check looks at the cycle right after its own stimulus.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int NUM_REGS = 7;
  localparam int SEL_W    = $clog2(NUM_REGS + 1);
  localparam int FLAG_W   = 8;
  localparam int IDX_USP  = 5;
  localparam int IDX_SSP  = 6;
  localparam logic [FLAG_W-1:0] STAT_RESET = 8'h04;

  typedef struct packed {
    logic                rdLoad;
    logic [NUM_REGS-1:0] wrHot;
    logic                flagLoad;
    logic                commit;
    logic                restore;
  } ctrlStrobes_t;
endpackage

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
  import rbk_pkg::*;
(
  input  logic             rdEn,
  input  logic [SEL_W-1:0] rdSel,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             flagWe,
  input  logic             instrDone,
  input  logic             abortReq,
  output ctrlStrobes_t     strobes
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_REGS - 1);

  always_comb begin
    strobes.rdLoad = rdEn && (rdSel <= LAST_SEL);
    for (int i = 0; i < NUM_REGS; i++) begin
      strobes.wrHot[i] = wrEn && (wrSel == SEL_W'(i));
    end
    strobes.restore  = abortReq;
    strobes.commit   = instrDone && !abortReq;
    strobes.flagLoad = flagWe && !abortReq;
  end
endmodule

// File: rtl/rbk_datapath.sv
module rbk_datapath
  import rbk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [FLAG_W-1:0] flagData,
  output logic [DATA_W-1:0] rdData,
  output logic [FLAG_W-1:0] statusOut
);
  logic [NUM_REGS-1:0][DATA_W-1:0] work;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_USP || i == IDX_SSP) begin : g_rollback
      logic [DATA_W-1:0] workQ, fallQ, workNext;
      always_comb workNext = strobes.wrHot[i] ? wrData : workQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          workQ <= '0;
          fallQ <= '0;
        end else if (strobes.restore) begin
          workQ <= fallQ;
        end else begin
          workQ <= workNext;
          if (strobes.commit) fallQ <= workNext;
        end
      end
      assign work[i] = workQ;
    end else begin : g_plain
      logic [DATA_W-1:0] workQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  workQ <= '0;
        else if (strobes.wrHot[i])  workQ <= wrData;
      end
      assign work[i] = workQ;
    end
  end

  logic [FLAG_W-1:0] statWork, statFall, statNext;
  always_comb statNext = strobes.flagLoad ? flagData : statWork;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statWork <= STAT_RESET;
      statFall <= STAT_RESET;
    end else if (strobes.restore) begin
      statWork <= statFall;
    end else begin
      statWork <= statNext;
      if (strobes.commit) statFall <= statNext;
    end
  end
  assign statusOut = statWork;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.rdLoad) rdData <= work[rdSel];
  end
endmodule

// File: rtl/rbk_regfile.sv
module rbk_regfile
  import rbk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [2:0]        rdSel,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flagWe,
  input  logic [7:0]        flagData,
  input  logic              instrDone,
  input  logic              abortReq,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        statusOut
);
  ctrlStrobes_t strobes;

  rbk_ctrl u_ctrl (
    .rdEn(rdEn), .rdSel(rdSel), .wrEn(wrEn), .wrSel(wrSel),
    .flagWe(flagWe), .instrDone(instrDone), .abortReq(abortReq),
    .strobes(strobes)
  );

  rbk_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .wrData(wrData), .flagData(flagData),
    .rdData(rdData), .statusOut(statusOut)
  );
endmodule

// File: rtl/rbk_regfile_chk.sv
module rbk_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [2:0]        rdSel,
  input logic              flagWe,
  input logic [7:0]        flagData,
  input logic              instrDone,
  input logic              abortReq,
  input logic [DATA_W-1:0] rdData,
  input logic [7:0]        statusOut
);
  logic [7:0] shadowStat;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowStat <= 8'h04;
    else if (instrDone && !abortReq) shadowStat <= flagWe ? flagData : statusOut;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && rdSel != 3'd7) |=> $stable(rdData)); // R3

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && !abortReq) |=> statusOut == $past(flagData)); // R9

  AST_STAT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!flagWe && !abortReq) |=> $stable(statusOut)); // R9

  AST_STAT_ROLLBACK: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> statusOut == $past(shadowStat)); // R7
endmodule

bind rbk_regfile rbk_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdSel(rdSel),
  .flagWe(flagWe), .flagData(flagData), .instrDone(instrDone),
  .abortReq(abortReq), .rdData(rdData), .statusOut(statusOut)
);

// File: tb/rbk_regfile_test.sv
module rbk_regfile_test;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0, wrEn = 1'b0, flagWe = 1'b0, instrDone = 1'b0, abortReq = 1'b0;
  logic [2:0] rdSel = '0, wrSel = '0;
  logic [W-1:0] wrData = '0;
  logic [7:0] flagData = '0;
  logic [W-1:0] rdData;
  logic [7:0] statusOut;

  always #2 clk = ~clk;

  rbk_regfile #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdSel(rdSel), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .flagWe(flagWe), .flagData(flagData),
    .instrDone(instrDone), .abortReq(abortReq),
    .rdData(rdData), .statusOut(statusOut)
  );

  typedef struct {
    logic [W-1:0] expRd;
    logic [7:0]   expStat;
    string        tag;
  } expItem_t;

  expItem_t sbQueue[$];
  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  // reference state, built from the requirements
  logic [W-1:0] mReg [7];
  logic [W-1:0] mFallUsp, mFallSsp, mRd;
  logic [7:0]   mStat, mStatFall;

  task automatic modelReset();
    for (int i = 0; i < 7; i++) mReg[i] = '0;
    mFallUsp = '0; mFallSsp = '0; mRd = '0;
    mStat = 8'h04; mStatFall = 8'h04;
  endtask

  task automatic step(input logic re, input logic [2:0] rs, input logic we,
                      input logic [2:0] ws, input logic [W-1:0] wd,
                      input logic fwe, input logic [7:0] fd,
                      input logic dn, input logic ab, input string tag);
    logic [W-1:0] nReg [7];
    logic [7:0] nStat;
    expItem_t item;
    @(negedge clk);
    rdEn = re; rdSel = rs; wrEn = we; wrSel = ws; wrData = wd;
    flagWe = fwe; flagData = fd; instrDone = dn; abortReq = ab;
    if (re && rs != 3'd7) mRd = mReg[rs];
    for (int i = 0; i < 7; i++) nReg[i] = mReg[i];
    if (we && ws != 3'd7) nReg[ws] = wd;
    nStat = fwe ? fd : mStat;
    if (ab) begin
      nReg[5] = mFallUsp; nReg[6] = mFallSsp; nStat = mStatFall;
    end else if (dn) begin
      mFallUsp = nReg[5]; mFallSsp = nReg[6]; mStatFall = nStat;
    end
    for (int i = 0; i < 7; i++) mReg[i] = nReg[i];
    mStat = nStat;
    @(posedge clk);
    #1;
    item.expRd = mRd; item.expStat = mStat; item.tag = tag;
    sbQueue.push_back(item);
  endtask

  task automatic rd(input logic [2:0] r, input string tag);
    step(1'b1, r, 1'b0, 3'd0, '0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [2:0] r, input logic [W-1:0] v, input string tag);
    step(1'b0, 3'd0, 1'b1, r, v, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares results one edge after each stimulus
  always @(negedge clk) begin
    while (sbQueue.size() > 0) begin
      expItem_t it;
      it = sbQueue.pop_front();
      vectors++;
      if (rdData !== it.expRd) begin
        misses++;
        $display("FAIL %s rdData actual %h expected %h", it.tag, rdData, it.expRd);
      end
      if (statusOut !== it.expStat) begin
        misses++;
        $display("FAIL %s statusOut actual %h expected %h", it.tag, statusOut, it.expStat);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      misses++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    modelReset();
    #9 rstN = 1'b1;
    // R9 reset state
    step(1'b0, 3'd0, 1'b0, 3'd0, '0, 1'b0, 8'h00, 1'b0, 1'b0, "R9");
    // R1 distinct value into each register, then R2 read each back
    for (int i = 0; i < 7; i++) wr(3'(i), 32'h1000_0000 + 32'(i * 17), "R1");
    for (int i = 0; i < 7; i++) rd(3'(i), "R2");
    // R3 hold when disabled or selecting 7
    step(1'b0, 3'd2, 1'b0, 3'd0, '0, 1'b0, 8'h00, 1'b0, 1'b0, "R3");
    rd(3'd7, "R3");
    // R4 read and write the same register in one cycle
    step(1'b1, 3'd1, 1'b1, 3'd1, 32'hCAFE_0001, 1'b0, 8'h00, 1'b0, 1'b0, "R4");
    rd(3'd1, "R4");
    // R5 write to number 7 touches nothing
    wr(3'd7, 32'hDEAD_BEEF, "R5");
    for (int i = 0; i < 7; i++) rd(3'(i), "R5");
    // R9 flag load
    step(1'b0, 3'd0, 1'b0, 3'd0, '0, 1'b1, 8'hA5, 1'b0, 1'b0, "R9");
    // R6 commit including same-cycle write and flag load
    step(1'b0, 3'd0, 1'b1, 3'd5, 32'h0000_5500, 1'b1, 8'h3C, 1'b1, 1'b0, "R6");
    wr(3'd5, 32'h0000_5511, "R6");
    wr(3'd6, 32'h0000_6611, "R6");
    step(1'b0, 3'd0, 1'b0, 3'd0, '0, 1'b1, 8'hFF, 1'b0, 1'b0, "R6");
    // R7 abort: A write kept, SSP write and flag write dropped
    step(1'b0, 3'd0, 1'b1, 3'd0, 32'h0A0A_0A0A, 1'b1, 8'h81, 1'b0, 1'b1, "R7");
    step(1'b1, 3'd6, 1'b1, 3'd6, 32'h7777_7777, 1'b0, 8'h00, 1'b0, 1'b1, "R7");
    rd(3'd5, "R7");
    rd(3'd6, "R7");
    rd(3'd0, "R7");
    // R8 abort and instruction end together: fallbacks untouched
    wr(3'd5, 32'h0000_8888, "R8");
    step(1'b0, 3'd0, 1'b1, 3'd6, 32'h0000_9999, 1'b1, 8'h42, 1'b1, 1'b1, "R8");
    rd(3'd5, "R8");
    step(1'b0, 3'd0, 1'b0, 3'd0, '0, 1'b1, 8'h10, 1'b0, 1'b0, "R8");
    step(1'b1, 3'd6, 1'b0, 3'd0, '0, 1'b0, 8'h00, 1'b0, 1'b1, "R8");
    rd(3'd5, "R8");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule